// File: doc/BRIEF.md
# Dual-Comparator Interval Timer with Match-Synchronized Outputs

This block is a peripheral timer built around a free-running 10-bit up-counter. A running bit starts the counter. It then advances once per slow tick. The slow tick comes from the peripheral clock, first halved and then divided again by a programmable factor. The counter wraps from 1023 back to 0. Two comparators watch the count. When the count reaches the active match value of a comparator, that comparator emits a single-cycle pulse and sets its own status flag. Any set flag drives the interrupt line.

Each comparator holds two values: a pending value, which software writes, and an active value, which the hardware compares against. The pending value is copied into the active value only on that comparator's match event. Software therefore sets up the next match from inside the current interrupt without disturbing the current one. A small output register works the same way. Software stages the bits, and they reach the pins only on the match pulse of the comparator chosen by a select bit.

Software reaches all registers over a byte-wide bus. Each read returns the addressed byte in the low half of a 16-bit word and the byte at the next address in the high half. Both bytes are taken in the same cycle. The count is split into an upper-bits byte followed by a lower-bits byte, so a single read at the upper address gives a coherent 10-bit count.

Top module: `mct_timer`

## Requirements
- R1: After reset, the count, both pending and active match values, the status flags, the staged bits, the select bit, the output pins, the interrupt line and both match pulses are all zero.
- R2: With the run bit set and divide factor N, the count advances by one every 2*(N+1) clock cycles. With the run bit clear, the count holds its value.
- R3: The count is 10 bits wide and wraps from 1023 to 0, so the full period of a fixed match is 1024 steps.
- R4: A comparator pulses `match_pulse[i]` high for exactly one cycle, in the cycle after the count takes a new value equal to its active match value. Both comparators can pulse in the same cycle.
- R5: A write to a comparator's pending value does not change the active value. The pending value becomes active at that comparator's next match event, so the match after a rewrite still happens at the old value. Reads of the match registers return the pending value.
- R6: A match pulse of comparator i sets status bit i (bit 0 for comparator 0, bit 1 for comparator 1). From the following cycle, `irq` is high whenever any status bit is set.
- R7: A read at the status address clears both status bits and returns their value from before the clear. If a match pulse falls in the same cycle as that read, the read returns the old bit, the bit stays set, and `irq` stays high.
- R8: The stage register holds output bits [3:0] and a select bit [7]. `out_pins` loads the staged bits in the cycle after a pulse from the selected comparator, and holds them through pulses from the other comparator.
- R9: A read started with `rd_en` returns `rdata` in the next cycle. `rdata[7:0]` is the byte at `addr` and `rdata[15:8]` is the byte at `addr+1`, both sampled in the same cycle. A read at address 8 returns the upper 2 count bits in `rdata[1:0]` and the lower 8 count bits in `rdata[15:8]`.
- R10: Register map: 0 run bit [0]; 1 divide factor N; 2 and 3 comparator 0 match upper 2 bits and lower 8 bits; 4 and 5 the same for comparator 1; 6 status; 7 stage; 8 count upper 2 bits; 9 count lower 8 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 16 | Read data: byte at addr in low half, byte at addr+1 in high half |
| irq | output | 1 | Interrupt request, high while any status flag is set |
| match_pulse | output | 2 | One-cycle match pulse per comparator |
| out_pins | output | 4 | Match-synchronized output bits |

## Verification
Two functions can fall in the same cycle: clearing the status flags by a read, and setting a flag by a match pulse. The bench provokes this by watching for a comparator pulse and asserting a status read in that very cycle. It then expects three things: the returned bit shows the old clear state, `irq` stays high, and a second read shows the flag still set. A second case puts the two comparators' pulses in one cycle at the first counter wrap, and the bench expects both pulses and both flags together.

// File: rtl/mct_pkg.sv
package mct_pkg;
  localparam int unsigned BUS_W  = 8;
  localparam int unsigned ADDR_W = 4;
  localparam int unsigned N_CMP  = 2;
  localparam int unsigned N_REGS = 1 << ADDR_W;

  localparam logic [ADDR_W-1:0] A_CTRL     = 4'h0;
  localparam logic [ADDR_W-1:0] A_DIV      = 4'h1;
  localparam logic [ADDR_W-1:0] A_CMP_BASE = 4'h2;
  localparam logic [ADDR_W-1:0] A_STAT     = 4'h6;
  localparam logic [ADDR_W-1:0] A_STAGE    = 4'h7;
  localparam logic [ADDR_W-1:0] A_CNT_HI   = 4'h8;
  localparam logic [ADDR_W-1:0] A_CNT_LO   = 4'h9;

  typedef logic [BUS_W-1:0] byte_t;
endpackage

// File: rtl/mct_prescaler.sv
module mct_prescaler #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             step_o
);
  logic             half_q;
  logic [DIV_W-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= 1'b0;
      pc_q   <= '0;
      step_o <= 1'b0;
    end else begin
      step_o <= 1'b0;
      if (!run_i) begin
        half_q <= 1'b0;
        pc_q   <= '0;
      end else begin
        half_q <= ~half_q;
        if (half_q) begin
          if (pc_q >= div_i) begin
            pc_q   <= '0;
            step_o <= 1'b1;
          end else begin
            pc_q <= pc_q + 1'b1;
          end
        end
      end
    end
  end

  // R2: steps are never back to back (half-rate base)
  p_step_gap_r2: assert property (@(posedge clk) disable iff (rst)
    step_o |=> !step_o);
endmodule

// File: rtl/mct_counter.sv
module mct_counter #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             moved_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o   <= '0;
      moved_o <= 1'b0;
    end else begin
      moved_o <= step_i;
      if (step_i) cnt_o <= cnt_o + 1'b1;
    end
  end

  // R2: count only moves on a prescaler step
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !step_i |=> $stable(cnt_o));
  // R3: arriving at zero only from the top value
  p_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (moved_o && cnt_o == '0) |-> $past(cnt_o) == CNT_MAX);
endmodule

// File: rtl/mct_comparator.sv
module mct_comparator #(
  parameter int unsigned CNT_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             moved_i,
  input  logic             wr_hi_i,
  input  logic             wr_lo_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] pend_o,
  output logic             match_o
);
  localparam int unsigned HI_W = CNT_W - 8;

  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] pend_q;
  logic             hit;

  assign hit    = moved_i && (cnt_i == act_q);
  assign pend_o = pend_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q   <= '0;
      pend_q  <= '0;
      match_o <= 1'b0;
    end else begin
      match_o <= hit;
      if (hit) act_q <= pend_q;
      if (wr_lo_i) pend_q[7:0] <= wdata_i;
      if (wr_hi_i) pend_q[CNT_W-1:8] <= wdata_i[HI_W-1:0];
    end
  end

  // R4: a match pulse lasts one cycle
  p_pulse_single_r4: assert property (@(posedge clk) disable iff (rst)
    match_o |=> !match_o);
  // R5: a software write alone never alters the active value
  p_write_defer_r5: assert property (@(posedge clk) disable iff (rst)
    ((wr_lo_i || wr_hi_i) && !hit) |=> act_q == $past(act_q));
endmodule

// File: rtl/mct_outstage.sv
module mct_outstage #(
  parameter int unsigned OUT_W = 4,
  parameter int unsigned NSRC  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_i,
  input  logic [OUT_W-1:0] bits_i,
  input  logic [((NSRC > 1) ? $clog2(NSRC) : 1)-1:0] sel_i,
  input  logic [NSRC-1:0]  match_i,
  output logic [OUT_W-1:0] stage_o,
  output logic [((NSRC > 1) ? $clog2(NSRC) : 1)-1:0] sel_o,
  output logic [OUT_W-1:0] pins_o
);
  logic load;
  assign load = match_i[sel_o];

  always_ff @(posedge clk) begin
    if (rst) begin
      stage_o <= '0;
      sel_o   <= '0;
      pins_o  <= '0;
    end else begin
      if (load) pins_o <= stage_o;
      if (wr_i) begin
        stage_o <= bits_i;
        sel_o   <= sel_i;
      end
    end
  end

  // R8: pins move only on the selected comparator's pulse
  p_pins_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !match_i[sel_o] |=> $stable(pins_o));
endmodule

// File: rtl/mct_timer.sv
module mct_timer
  import mct_pkg::*;
#(
  parameter int unsigned CNT_W = 10,
  parameter int unsigned DIV_W = 8,
  parameter int unsigned OUT_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [BUS_W-1:0]    wdata,
  output logic [2*BUS_W-1:0]  rdata,
  output logic                irq,
  output logic [N_CMP-1:0]    match_pulse,
  output logic [OUT_W-1:0]    out_pins
);
  localparam int unsigned HI_W  = CNT_W - BUS_W;
  localparam int unsigned SEL_W = (N_CMP > 1) ? $clog2(N_CMP) : 1;

  logic             run_q;
  logic [DIV_W-1:0] div_q;
  logic [N_CMP-1:0] flag_q;
  logic [N_CMP-1:0] flag_nx;
  logic             step;
  logic             moved;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] pend [N_CMP];
  logic [OUT_W-1:0] stage;
  logic [SEL_W-1:0] sel;
  logic             clr;
  logic [ADDR_W-1:0] addr_nx;
  byte_t            regs_v [N_REGS];

  mct_prescaler #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .run_i(run_q), .div_i(div_q), .step_o(step)
  );

  mct_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step_i(step), .cnt_o(cnt), .moved_o(moved)
  );

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic wr_hi, wr_lo;
    assign wr_hi = wr_en && (addr == A_CMP_BASE + ADDR_W'(2*i));
    assign wr_lo = wr_en && (addr == A_CMP_BASE + ADDR_W'(2*i + 1));

    mct_comparator #(.CNT_W(CNT_W)) u_cmp (
      .clk(clk), .rst(rst), .cnt_i(cnt), .moved_i(moved),
      .wr_hi_i(wr_hi), .wr_lo_i(wr_lo), .wdata_i(wdata),
      .pend_o(pend[i]), .match_o(match_pulse[i])
    );

    // R6: a pulse always leaves its flag set (set beats clear, R7)
    p_flag_set_r6: assert property (@(posedge clk) disable iff (rst)
      match_pulse[i] |=> flag_q[i]);
  end

  mct_outstage #(.OUT_W(OUT_W), .NSRC(N_CMP)) u_out (
    .clk(clk), .rst(rst),
    .wr_i(wr_en && addr == A_STAGE),
    .bits_i(wdata[OUT_W-1:0]),
    .sel_i(wdata[BUS_W-1 -: SEL_W]),
    .match_i(match_pulse),
    .stage_o(stage), .sel_o(sel), .pins_o(out_pins)
  );

  assign clr     = rd_en && (addr == A_STAT);
  assign flag_nx = (flag_q & ~{N_CMP{clr}}) | match_pulse;
  assign addr_nx = addr + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      div_q  <= '0;
      flag_q <= '0;
      irq    <= 1'b0;
    end else begin
      flag_q <= flag_nx;
      irq    <= |flag_nx;
      if (wr_en && addr == A_CTRL) run_q <= wdata[0];
      if (wr_en && addr == A_DIV)  div_q <= wdata[DIV_W-1:0];
    end
  end

  always_comb begin
    for (int k = 0; k < N_REGS; k++) regs_v[k] = '0;
    regs_v[A_CTRL][0]           = run_q;
    regs_v[A_DIV][DIV_W-1:0]    = div_q;
    for (int k = 0; k < N_CMP; k++) begin
      regs_v[A_CMP_BASE + ADDR_W'(2*k)][HI_W-1:0] = pend[k][CNT_W-1:BUS_W];
      regs_v[A_CMP_BASE + ADDR_W'(2*k + 1)]       = pend[k][BUS_W-1:0];
    end
    regs_v[A_STAT][N_CMP-1:0]   = flag_q;
    regs_v[A_STAGE][OUT_W-1:0]  = stage;
    regs_v[A_STAGE][BUS_W-1 -: SEL_W] = sel;
    regs_v[A_CNT_HI][HI_W-1:0]  = cnt[CNT_W-1:BUS_W];
    regs_v[A_CNT_LO]            = cnt[BUS_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else if (rd_en) rdata <= {regs_v[addr_nx], regs_v[addr]};
  end

  // R6: the interrupt line follows the flags
  p_irq_tracks_r6: assert property (@(posedge clk) disable iff (rst)
    irq == (|flag_q));
  // R7: a status read with no pulse leaves the flags empty
  p_clear_r7: assert property (@(posedge clk) disable iff (rst)
    (clr && match_pulse == '0) |=> flag_q == '0);
endmodule

// File: tb/mct_timer_tb_top.sv
module mct_timer_tb_top;
  import mct_pkg::*;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [15:0] rdata;
  logic        irq;
  logic [1:0]  match_pulse;
  logic [3:0]  out_pins;

  always #2 clk = ~clk; // 250 MHz

  mct_timer dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .irq(irq), .match_pulse(match_pulse),
    .out_pins(out_pins)
  );

  int checks = 0, failures = 0;
  int cyc = 0;
  int npulse [2] = '{0, 0};
  int last_t [2] = '{0, 0};
  int first_t [2] = '{0, 0};
  logic [1:0] prev_p = 2'b00;
  int q0[$];
  int q1[$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [15:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  // Scoreboard monitor: gaps between successive pulses of each comparator
  always @(negedge clk) begin
    cyc = cyc + 1;
    if (!rst) begin
      for (int i = 0; i < 2; i++) begin
        if (match_pulse[i]) begin
          check(!prev_p[i], "R4 pulse width", 2, 1);
          if (npulse[i] > 0) begin
            int e;
            e = -2;
            if (i == 0 && q0.size() > 0) e = q0.pop_front();
            if (i == 1 && q1.size() > 0) e = q1.pop_front();
            if (e >= 0)
              check(cyc - last_t[i] == e, "R2/R3/R5 match gap", cyc - last_t[i], e);
          end else begin
            first_t[i] = cyc;
          end
          last_t[i] = cyc;
          npulse[i] = npulse[i] + 1;
        end
      end
      prev_p = match_pulse;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] d, d2;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(out_pins == 4'h0, "R1 pins", out_pins, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);
    check(match_pulse == 2'b00, "R1 pulses", match_pulse, 0);
    bus_read(A_CNT_HI, d);
    check(d == 16'h0000, "R1 count", d, 0);
    bus_read(A_CMP_BASE, d);
    check(d == 16'h0000, "R1 match0", d, 0);

    // comparator 0: 0 -> 10 (20 clk), 10 again after rewrite (2048), 300 (580), lap
    q0.push_back(20); q0.push_back(2048); q0.push_back(580); q0.push_back(2048);
    q1.push_back(40); q1.push_back(2048);
    bus_write(A_CMP_BASE + 4'd1, 8'd10);
    bus_write(A_CMP_BASE + 4'd3, 8'd20);
    bus_write(A_CTRL, 8'h01);

    wait (npulse[0] >= 1 && npulse[1] >= 1);
    check(first_t[0] == first_t[1], "R4 coincident pulses", first_t[1], first_t[0]);
    @(negedge clk);
    check(irq == 1'b1, "R6 irq after match", irq, 1);
    bus_read(A_STAT, d);
    check(d[1:0] == 2'b11, "R6 status bits", d[1:0], 3);
    check(irq == 1'b0, "R7 irq after clear", irq, 0);
    bus_write(A_STAGE, 8'h8A); // select comparator 1, bits 0xA

    wait (npulse[0] >= 2);
    @(negedge clk);
    check(out_pins == 4'h0, "R8 other comparator ignored", out_pins, 0);
    bus_write(A_CMP_BASE, 8'h01);
    bus_write(A_CMP_BASE + 4'd1, 8'h2C);
    bus_read(A_CMP_BASE, d);
    check(d == 16'h2C01, "R5 R10 pending readback", d, 16'h2C01);

    wait (npulse[1] >= 2);
    @(negedge clk);
    check(out_pins == 4'hA, "R8 selected comparator loads", out_pins, 10);
    bus_read(A_STAT, d);

    // R7 collision: status read in the cycle of a comparator-1 pulse
    @(negedge clk);
    while (!match_pulse[1]) @(negedge clk);
    bus_read(A_STAT, d);
    check(d[1] == 1'b0, "R7 read returns old bit", d[1], 0);
    check(irq == 1'b1, "R7 irq survives", irq, 1);
    bus_read(A_STAT, d);
    check(d[1] == 1'b1, "R7 flag survives", d[1], 1);

    wait (npulse[0] >= 5);
    bus_write(A_DIV, 8'd3);
    q0.push_back(-1); q0.push_back(8192);
    wait (npulse[0] >= 6);
    @(negedge clk);
    while (!match_pulse[0]) @(negedge clk);
    bus_read(A_CNT_HI, d);
    check(d == 16'h2C01, "R9 split count read", d, 16'h2C01);

    // R2 stopped counter holds
    bus_write(A_CTRL, 8'h00);
    repeat (10) @(negedge clk);
    bus_read(A_CNT_LO, d);
    repeat (40) @(negedge clk);
    bus_read(A_CNT_LO, d2);
    check(d == d2, "R2 stopped count holds", d2, d);
    check(q0.size() == 0, "R5 all comparator-0 gaps seen", q0.size(), 0);
    check(q1.size() == 0, "R4 all comparator-1 gaps seen", q1.size(), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule